// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a 12-bit charge-balancing successive-approximation converter. It counts each conversion through a fixed frame of clock periods. For the first periods of the frame it holds the sampling network in track mode while the comparator auto-zeroes. It then runs one bit trial per period, from the most significant bit down. For each trial it drives a vector that says which capacitor goes to the high reference, and it reads a one-bit comparator decision. When the last trial is done, the full code moves into an output register and a data-ready flag rises.

The capacitor array and the comparator are outside the block. The comparator input `cmp_hi` must be 1 when the held input is at or above the level set by `trial_bits`. A low level on the active-low start input lets the block run back to back. Holding start high parks the sequencer early in the next frame, still tracking, until a start arrives. This gives single-shot operation.

Top module: `sar_seq_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the sequencer in period 1 with `track` high, `hold` low, `ready` low, `trial_bits` zero and `result` zero.
- R2: With `start_n` held low, a conversion takes exactly 15 clock periods. The edge that ends period 15 returns `period` to 1 and sets `ready` high.
- R3: In periods 1 to 3, `track` is 1, `hold` is 0 and `trial_bits` is all zero. In periods 4 to 15, `hold` is 1 and `track` is 0.
- R4: In period 4, `trial_bits` has only bit 11 (MSB) set, which tests the input against half scale (code 2048).
- R5: Period p (4 to 15) tests bit 15-p. That bit of `trial_bits` is 1 during its trial. At the end of the period it stays 1 if `cmp_hi` was 1 and becomes 0 otherwise. The bits above it carry earlier decisions and the bits below it are 0.
- R6: `result` changes only on the edge that ends period 15. It then holds every bit decision of the finished conversion, with bit 0 taken from `cmp_hi` in period 15. It stays unchanged for the whole following conversion.
- R7: `ready` stays high for exactly period 1 in free-running operation. It is low from the start of period 2 (or from the resumed period 3) until the next period-15 end.
- R8: `start_n` is sampled only on the edge that ends period 1 and while parked. Its level in periods 3 to 15 has no effect on the period sequence or the result.
- R9: If `start_n` is high on the edge that ends period 1, the sequencer enters period 2 and stays there with `track` high and `ready` held. On the first edge with `start_n` low it moves to period 3 and clears `ready`.
- R10: The code is straight binary. With an ideal comparator, an input at full scale gives 4095, an input at zero gives 0, and any input code v gives v.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_n | input | 1 | Start request, active low |
| cmp_hi | input | 1 | Comparator decision: 1 when the input is at or above the trial level |
| track | output | 1 | Sampling network tracks the input, comparator auto-zeroes |
| hold | output | 1 | Input is held, bit trials in progress |
| trial_bits | output | 12 | Per-capacitor reference select, 1 = high reference |
| period | output | 4 | Current period number, 1 to 15 |
| result | output | 12 | Last completed conversion code |
| ready | output | 1 | Data-ready flag |

## Verification
The assertions assume that `cmp_hi` reflects an input that is steady through the hold periods. They also assume that reset is applied before the first frame and that `start_n` is a clean synchronous level. The bench meets these assumptions as follows. It models the comparator as an ideal compare of a fixed digital input code against `trial_bits`. It changes that code and `start_n` only at falling clock edges. It never alters the code between period 4 and the end of the frame. It toggles `start_n` in the middle of a frame on purpose, only to show that mid-frame levels are ignored.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    localparam int unsigned SEQ_NBITS  = 12;
    localparam int unsigned SEQ_NTRACK = 3;

    typedef enum logic [1:0] {
        PH_TRACK = 2'd0,
        PH_PARK  = 2'd1,
        PH_TRIAL = 2'd2
    } seq_phase_e;

    function automatic int unsigned trial_period(input int unsigned bit_idx,
                                                 input int unsigned nbits,
                                                 input int unsigned ntrack);
        return ntrack + nbits - bit_idx;
    endfunction

endpackage

// File: rtl/sar_period_ctr.sv
module sar_period_ctr
    import sar_seq_pkg::*;
#(
    parameter int unsigned NBITS  = SEQ_NBITS,
    parameter int unsigned NTRACK = SEQ_NTRACK,
    localparam int unsigned LAST  = NBITS + NTRACK,
    localparam int unsigned PW    = $clog2(LAST + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_n,
    output logic [PW-1:0] period,
    output seq_phase_e    phase,
    output logic          ready,
    output logic          last
);

    localparam logic [PW-1:0] P_ONE  = PW'(1);
    localparam logic [PW-1:0] P_TWO  = PW'(2);
    localparam logic [PW-1:0] P_TRK  = PW'(NTRACK);
    localparam logic [PW-1:0] P_LAST = PW'(LAST);

    logic [PW-1:0] per_q;
    logic          park_q;
    logic          rdy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            per_q  <= P_ONE;
            park_q <= 1'b0;
            rdy_q  <= 1'b0;
        end else if (per_q == P_LAST) begin
            per_q  <= P_ONE;
            park_q <= 1'b0;
            rdy_q  <= 1'b1;
        end else if (per_q == P_ONE) begin
            per_q <= P_TWO;
            if (start_n) begin
                park_q <= 1'b1;
            end else begin
                rdy_q <= 1'b0;
            end
        end else if (park_q) begin
            if (!start_n) begin
                park_q <= 1'b0;
                rdy_q  <= 1'b0;
                per_q  <= P_TWO + P_ONE;
            end
        end else begin
            per_q <= per_q + P_ONE;
        end
    end

    always_comb begin
        if (park_q)              phase = PH_PARK;
        else if (per_q <= P_TRK) phase = PH_TRACK;
        else                     phase = PH_TRIAL;
    end

    assign period = per_q;
    assign ready  = rdy_q;
    assign last   = (per_q == P_LAST);

    // R1: period stays within the frame
    a_r1_period_legal: assert property (@(posedge clk) disable iff (rst)
        (per_q >= P_ONE) && (per_q <= P_LAST));

    // R2: end of frame wraps to period 1 with ready raised
    a_r2_wrap_ready: assert property (@(posedge clk) disable iff (rst)
        (per_q == P_LAST) |=> (rdy_q && per_q == P_ONE));

    // R7: ready low outside period 1 unless parked
    a_r7_ready_low: assert property (@(posedge clk) disable iff (rst)
        (per_q != P_ONE && !park_q) |-> !rdy_q);

    // R8: mid-frame periods always advance by one
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (per_q > P_TWO && per_q < P_LAST) |=> (per_q == $past(per_q) + P_ONE));

    // R9: parked without start keeps period 2 and ready
    a_r9_park_holds: assert property (@(posedge clk) disable iff (rst)
        (park_q && start_n) |=> (per_q == P_TWO && $stable(rdy_q)));

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg
    import sar_seq_pkg::*;
#(
    parameter int unsigned NBITS  = SEQ_NBITS,
    parameter int unsigned NTRACK = SEQ_NTRACK,
    localparam int unsigned LAST  = NBITS + NTRACK,
    localparam int unsigned PW    = $clog2(LAST + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PW-1:0]    period,
    input  logic             cmp_hi,
    output logic [NBITS-1:0] trial_bits,
    output logic [NBITS-1:0] decided
);

    localparam logic [NBITS-1:0] MSB_ONLY = NBITS'(1) << (NBITS - 1);

    logic [NBITS-1:0] ptr;
    logic [NBITS-1:0] acc_q;
    logic             trial_en;

    for (genvar i = 0; i < NBITS; i++) begin : g_ptr
        assign ptr[i] = (period == PW'(trial_period(i, NBITS, NTRACK)));
    end

    assign trial_en   = |ptr;
    assign decided    = (acc_q & ~ptr) | (ptr & {NBITS{cmp_hi}});
    assign trial_bits = trial_en ? (acc_q | ptr) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (trial_en) begin
            acc_q <= decided;
        end else begin
            acc_q <= '0;
        end
    end

    // R4: first trial tests MSB alone
    a_r4_msb_first: assert property (@(posedge clk) disable iff (rst)
        (period == PW'(NTRACK + 1)) |-> (trial_bits == MSB_ONLY));

    // R5: at most one bit under trial
    a_r5_single_ptr: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ptr));

    // R5: tested bit keeps the comparator decision
    a_r5_bit_kept: assert property (@(posedge clk) disable iff (rst)
        trial_en |=> ((acc_q & $past(ptr)) == ($past(cmp_hi) ? $past(ptr) : '0)));

endmodule

// File: rtl/sar_out_reg.sv
module sar_out_reg
    import sar_seq_pkg::*;
#(
    parameter int unsigned NBITS = SEQ_NBITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [NBITS-1:0] din,
    output logic [NBITS-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= din;
    end

    // R6: result only changes at end of frame
    a_r6_result_stable: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int unsigned NBITS  = SEQ_NBITS,
    parameter int unsigned NTRACK = SEQ_NTRACK,
    localparam int unsigned LAST  = NBITS + NTRACK,
    localparam int unsigned PW    = $clog2(LAST + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_n,
    input  logic             cmp_hi,
    output logic             track,
    output logic             hold,
    output logic [NBITS-1:0] trial_bits,
    output logic [PW-1:0]    period,
    output logic [NBITS-1:0] result,
    output logic             ready
);

    seq_phase_e       phase;
    logic             last;
    logic [NBITS-1:0] decided;

    sar_period_ctr #(.NBITS(NBITS), .NTRACK(NTRACK)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .start_n (start_n),
        .period  (period),
        .phase   (phase),
        .ready   (ready),
        .last    (last)
    );

    sar_trial_reg #(.NBITS(NBITS), .NTRACK(NTRACK)) u_trial (
        .clk        (clk),
        .rst        (rst),
        .period     (period),
        .cmp_hi     (cmp_hi),
        .trial_bits (trial_bits),
        .decided    (decided)
    );

    sar_out_reg #(.NBITS(NBITS)) u_out (
        .clk  (clk),
        .rst  (rst),
        .load (last),
        .din  (decided),
        .q    (result)
    );

    assign hold  = (phase == PH_TRIAL);
    assign track = !hold;

    // R3: no reference switching while tracking
    a_r3_track_idle: assert property (@(posedge clk) disable iff (rst)
        track |-> (trial_bits == '0));

endmodule

// File: tb/sar_seq_ctrl_tb.sv
module sar_seq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_n = 1'b0;
    logic [11:0] vin = '0;
    logic        cmp_hi;
    logic        track, hold, ready;
    logic [11:0] trial_bits, result;
    logic [3:0]  period;

    int n_chk = 0;
    int n_err = 0;
    logic [11:0] exp_res = '0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    assign cmp_hi = (vin >= trial_bits);

    sar_seq_ctrl u_dut (
        .clk(clk), .rst(rst), .start_n(start_n), .cmp_hi(cmp_hi),
        .track(track), .hold(hold), .trial_bits(trial_bits),
        .period(period), .result(result), .ready(ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        exp_res = '0;
        chk(period == 4'd1, "R1 period", period, 1);
        chk(track == 1'b1 && hold == 1'b0, "R1 track", track, 1);
        chk(ready == 1'b0, "R1 ready", ready, 0);
        chk(result == 12'd0, "R1 result", result, 0);
        chk(trial_bits == 12'd0, "R1 trial_bits", trial_bits, 0);
    endtask

    // Free-running frame from period 1; optional mid-frame start toggling (R8)
    task automatic t_convert(input logic [11:0] v, input bit wiggle);
        logic [11:0] e5;
        vin = v;
        start_n = 1'b0;
        e5 = {v[11], 11'b0} | 12'h400;
        for (int k = 1; k <= 14; k++) begin
            step();
            chk(period == 4'(k + 1), "R2 period count", period, k + 1);
            if (k == 1) chk(ready == 1'b0, "R7 ready drop", ready, 0);
            if (k + 1 <= 3) begin
                chk(track && !hold && trial_bits == 12'd0, "R3 track phase", trial_bits, 0);
            end else begin
                chk(hold && !track, "R3 hold phase", hold, 1);
            end
            if (k + 1 == 4) chk(trial_bits == 12'h800, "R4 msb trial", trial_bits, 12'h800);
            if (k + 1 == 5) chk(trial_bits == e5, "R5 second trial", trial_bits, e5);
            chk(result == exp_res, "R6 result held", result, exp_res);
            if (wiggle && k + 1 == 3) start_n = 1'b1;
            if (wiggle && k + 1 == 9) start_n = 1'b0;
            if (wiggle && k + 1 == 10) start_n = 1'b1;
            if (k + 1 == 14) start_n = 1'b0;
        end
        step();
        exp_res = v;
        chk(period == 4'd1, "R2 wrap", period, 1);
        chk(ready == 1'b1, "R2 ready high", ready, 1);
        chk(result == v, wiggle ? "R8 result" : "R10 code", result, v);
    endtask

    // Park in period 2, then start (R9)
    task automatic t_single_shot(input logic [11:0] v, input int park_cycles);
        start_n = 1'b1;
        step();
        chk(period == 4'd2, "R9 enter park", period, 2);
        for (int i = 0; i < park_cycles; i++) begin
            step();
            chk(period == 4'd2, "R9 parked period", period, 2);
            chk(ready == 1'b1, "R9 ready held", ready, 1);
            chk(track == 1'b1, "R9 tracking", track, 1);
        end
        vin = v;
        start_n = 1'b0;
        step();
        chk(period == 4'd3, "R9 resume", period, 3);
        chk(ready == 1'b0, "R9 ready cleared", ready, 0);
        for (int k = 4; k <= 15; k++) begin
            step();
            chk(period == 4'(k), "R9 post-resume count", period, k);
            chk(result == exp_res, "R6 held in shot", result, exp_res);
        end
        step();
        exp_res = v;
        chk(ready == 1'b1 && period == 4'd1, "R9 shot done", ready, 1);
        chk(result == v, "R9 shot code", result, v);
    endtask

    initial begin
        t_reset();
        t_convert(12'd4095, 1'b0);
        t_convert(12'd0, 1'b0);
        t_convert(12'd2048, 1'b0);
        t_convert(12'd2047, 1'b1);
        t_convert(12'hA5C, 1'b0);
        t_convert(12'd1, 1'b1);
        t_single_shot(12'h3C7, 6);
        t_single_shot(12'hFFE, 0);
        t_convert(12'h555, 1'b0);
        t_reset();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule